// File: doc/BRIEF.md
# Shared Broadcast Bus with Word Memory

This block is the interconnect shared by four cache nodes and a small word memory. Each node raises a request that holds a packet: a kind (read or write), a word address and a data word. The bus gives ownership to one node at a time and puts that node's packet on a single set of broadcast outputs, which every cache and the memory observe. The packet's source field is the node's index.

The built-in memory answers every read or write packet with an acknowledge packet, after a fixed parameterised delay. The acknowledge goes out on the same broadcast outputs and carries the requester's source index. This lets each cache recognise its own reply, and lets the other caches watch write traffic. Only one transaction is in flight at a time.

The block also watches a count of finished nodes. Once that count reaches the node total, it stops the run and issues no further grants.

Top module: `snoop_bus`

## Requirements
- R1: While reset is asserted and right after it, no grant is active, `bus_valid` and `run_stop` are low, and every memory word reads as zero.
- R2: The cycle after the bus is idle and at least one request is pending, the winner's packet appears on the bus with `bus_valid` high. `bus_type` carries the request kind (1 = read, 2 = write, 3 = acknowledge), and `bus_addr` and `bus_data` carry the request fields. `bus_src` is the winner's index.
- R3: Arbitration is round-robin. The search starts at the node after the last winner, and node 0 is searched first after reset.
- R4: `grant` is one-hot or zero. It is held unchanged from the request broadcast through the acknowledge cycle, drops in the cycle after, and stays low for at least that one cycle before the next grant.
- R5: The acknowledge (kind 3) appears exactly `ACK_LAT` cycles after its request broadcast. Its `bus_src` equals the requester's index.
- R6: An acknowledge for a read carries the memory word currently stored at the request address.
- R7: A write stores its data when the request is accepted. Its acknowledge repeats the write address and data.
- R8: `bus_valid` is high only while a grant is active, and only in the request and acknowledge cycles.
- R9: `run_stop` rises the cycle after `done_count` equals `NODES`, and then stays high. After it rises, no new grant is issued, but a transaction already in flight completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NODES | Per-node request pending |
| req_type | input | 2*NODES | Per-node request kind, 2 bits each |
| req_addr | input | NODES*clog2(MEM_WORDS) | Per-node word address |
| req_data | input | NODES*DATA_W | Per-node write data |
| done_count | input | clog2(NODES+1) | Number of nodes that have finished |
| grant | output | NODES | One-hot current bus owner |
| bus_valid | output | 1 | Broadcast packet present this cycle |
| bus_type | output | 2 | Packet kind on the bus |
| bus_addr | output | clog2(MEM_WORDS) | Packet address |
| bus_data | output | DATA_W | Packet data |
| bus_src | output | clog2(NODES) | Originating node index |
| run_stop | output | 1 | Run finished, sticky |

## Verification
The hardest states to reach are full contention and a stop that lands mid-transaction. For contention, all four nodes must be waiting at the same arbitration cycle, which shows the rotation order and the forced idle gap. For the stop, the finished count must reach the node total while a grant is in flight and more requests are queued. The bench loads every node's request queue before reset is released, so the first arbitration sees all four contenders. It then raises the finished count a few cycles after a fresh burst from one node, so the in-flight acknowledge must still complete while the rest of that node's queue must never be granted.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_RD   = 2'd1,
    PK_WR   = 2'd2,
    PK_ACK  = 2'd3
  } pkt_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } bus_st_e;
endpackage

// File: rtl/snoop_rr_pick.sv
module snoop_rr_pick #(
  parameter int N  = 4,
  parameter int SW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [SW-1:0] last,
  output logic          any,
  output logic [SW-1:0] idx
);
  // Scan from farthest to nearest so the nearest requester after last wins.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N; i >= 1; i--) begin
      if (req[(int'(last) + i) % N]) begin
        any = 1'b1;
        idx = SW'((int'(last) + i) % N);
      end
    end
  end
endmodule

// File: rtl/snoop_mem.sv
module snoop_mem #(
  parameter int WORDS  = 16,
  parameter int DATA_W = 16,
  parameter int AW     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/snoop_bus.sv
module snoop_bus
  import snoop_pkg::*;
#(
  parameter int NODES     = 4,
  parameter int MEM_WORDS = 16,
  parameter int DATA_W    = 16,
  parameter int ACK_LAT   = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NODES-1:0]                    req_valid,
  input  logic [2*NODES-1:0]                  req_type,
  input  logic [NODES*$clog2(MEM_WORDS)-1:0]  req_addr,
  input  logic [NODES*DATA_W-1:0]             req_data,
  input  logic [$clog2(NODES+1)-1:0]          done_count,
  output logic [NODES-1:0]                    grant,
  output logic                                bus_valid,
  output logic [1:0]                          bus_type,
  output logic [$clog2(MEM_WORDS)-1:0]        bus_addr,
  output logic [DATA_W-1:0]                   bus_data,
  output logic [$clog2(NODES)-1:0]            bus_src,
  output logic                                run_stop
);
  localparam int AW  = $clog2(MEM_WORDS);
  localparam int SW  = $clog2(NODES);
  localparam int DCW = $clog2(NODES + 1);
  localparam int CW  = $clog2(ACK_LAT + 1);

  bus_st_e           st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [SW-1:0]     last_q, last_d, src_q, src_d;
  pkt_kind_e         kind_q, kind_d, bt_q, bt_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              bv_q, bv_d, stop_q, stop_d;

  logic              pick_any;
  logic [SW-1:0]     pick_idx;
  logic              mem_we;
  logic [DATA_W-1:0] mem_rdata;

  snoop_rr_pick #(.N(NODES), .SW(SW)) i_pick (
    .req  (req_valid),
    .last (last_q),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  snoop_mem #(.WORDS(MEM_WORDS), .DATA_W(DATA_W), .AW(AW)) i_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (addr_d),
    .wdata (data_d),
    .raddr (addr_q),
    .rdata (mem_rdata)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    src_d  = src_q;
    kind_d = kind_q;
    addr_d = addr_q;
    data_d = data_q;
    bv_d   = 1'b0;
    bt_d   = PK_NONE;
    mem_we = 1'b0;
    stop_d = stop_q | (done_count == DCW'(NODES));
    unique case (st_q)
      ST_IDLE: begin
        if (pick_any && !stop_q) begin
          st_d   = ST_WAIT;
          src_d  = pick_idx;
          last_d = pick_idx;
          kind_d = pkt_kind_e'(req_type[int'(pick_idx)*2 +: 2]);
          addr_d = req_addr[int'(pick_idx)*AW +: AW];
          data_d = req_data[int'(pick_idx)*DATA_W +: DATA_W];
          cnt_d  = CW'(ACK_LAT - 1);
          bv_d   = 1'b1;
          bt_d   = kind_d;
          mem_we = (kind_d == PK_WR);
        end
      end
      ST_WAIT: begin
        if (cnt_q == '0) begin
          st_d = ST_ACK;
          bv_d = 1'b1;
          bt_d = PK_ACK;
          if (kind_q == PK_RD) data_d = mem_rdata;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_ACK:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      last_q <= SW'(NODES - 1);
      src_q  <= '0;
      kind_q <= PK_NONE;
      addr_q <= '0;
      data_q <= '0;
      bv_q   <= 1'b0;
      bt_q   <= PK_NONE;
      stop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
      src_q  <= src_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
      data_q <= data_d;
      bv_q   <= bv_d;
      bt_q   <= bt_d;
      stop_q <= stop_d;
    end
  end

  assign grant     = (st_q != ST_IDLE) ? (NODES'(1) << src_q) : '0;
  assign bus_valid = bv_q;
  assign bus_type  = bt_q;
  assign bus_addr  = addr_q;
  assign bus_data  = data_q;
  assign bus_src   = src_q;
  assign run_stop  = stop_q;

  // R4
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !(bus_valid && bus_type == PK_ACK)) |=> $stable(grant));
  // R4
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_type == PK_ACK) |=> grant == '0);
  // R8
  bus_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> grant != '0);
  // R5
  ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_type == PK_ACK) |-> grant[bus_src]);
  // R9
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_stop |=> run_stop);
  // R9
  stop_nogrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_stop && grant == '0) |=> grant == '0);
endmodule

// File: tb/test_snoop_bus.sv
module test_snoop_bus;
  localparam int N   = 4;
  localparam int MW  = 16;
  localparam int DW  = 16;
  localparam int LAT = 3;
  localparam int AW  = 4;
  localparam int SW  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      req_valid;
  logic [2*N-1:0]    req_type;
  logic [N*AW-1:0]   req_addr;
  logic [N*DW-1:0]   req_data;
  logic [2:0]        done_count;
  logic [N-1:0]      grant;
  logic              bus_valid;
  logic [1:0]        bus_type;
  logic [AW-1:0]     bus_addr;
  logic [DW-1:0]     bus_data;
  logic [SW-1:0]     bus_src;
  logic              run_stop;

  snoop_bus #(.NODES(N), .MEM_WORDS(MW), .DATA_W(DW), .ACK_LAT(LAT)) i_snoop_bus (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_data(req_data), .done_count(done_count),
    .grant(grant), .bus_valid(bus_valid), .bus_type(bus_type),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_src(bus_src), .run_stop(run_stop)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int req_cyc = 0;
  int order[$];
  logic [31:0] nq[N][$];

  // reference model state
  int m_st, m_cnt, m_last, m_src, m_kind, m_addr, m_data, found;
  bit m_stop, nstop;
  int m_mem[MW];
  int e_valid, e_type, e_addr, e_data, e_src;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] pk(int kind, int addr, int data);
    return {6'd0, 2'(kind), 8'(addr), 16'(data)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_last = N - 1; m_src = 0; m_stop = 0;
      e_valid = 0; e_type = 0; e_addr = 0; e_data = 0; e_src = 0;
      for (int i = 0; i < MW; i++) m_mem[i] = 0;
    end else begin
      nstop = m_stop || (done_count == N);
      e_valid = 0;
      case (m_st)
        0: if (!m_stop) begin
          found = -1;
          for (int i = 1; i <= N; i++)
            if (found < 0 && req_valid[(m_last + i) % N]) found = (m_last + i) % N;
          if (found >= 0) begin
            m_src = found; m_last = found;
            m_kind = int'(req_type[found*2 +: 2]);
            m_addr = int'(req_addr[found*AW +: AW]);
            m_data = int'(req_data[found*DW +: DW]);
            if (m_kind == 2) m_mem[m_addr] = m_data;
            m_cnt = LAT - 1;
            e_valid = 1; e_type = m_kind; e_addr = m_addr; e_data = m_data; e_src = found;
            m_st = 1;
          end
        end
        1: if (m_cnt == 0) begin
          e_valid = 1; e_type = 3; e_addr = m_addr; e_src = m_src;
          e_data = (m_kind == 1) ? m_mem[m_addr] : m_data;
          m_st = 2;
        end else m_cnt--;
        default: m_st = 0;
      endcase
      m_stop = nstop;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R4 grant", int'(grant), (m_st != 0) ? (1 << m_src) : 0);
      chk("R8 bus_valid", int'(bus_valid), e_valid);
      chk("R9 run_stop", int'(run_stop), int'(m_stop));
      if (bus_valid && e_valid != 0) begin
        chk("R2 bus_type", int'(bus_type), e_type);
        chk("R2 bus_src", int'(bus_src), e_src);
        chk("R2 R7 bus_addr", int'(bus_addr), e_addr);
        chk("R6 R7 bus_data", int'(bus_data), e_data);
      end
      if (bus_valid && bus_type != 2'd3) begin
        req_cyc = cyc;
        order.push_back(int'(bus_src));
      end
      if (bus_valid && bus_type == 2'd3) begin
        chk("R5 ack latency", cyc - req_cyc, LAT);
        if (nq[bus_src].size() > 0) void'(nq[bus_src].pop_front());
      end
    end
    for (int n = 0; n < N; n++) begin
      req_valid[n] = (nq[n].size() > 0);
      if (nq[n].size() > 0) begin
        req_type[n*2 +: 2]   = nq[n][0][25:24];
        req_addr[n*AW +: AW] = nq[n][0][AW+15:16];
        req_data[n*DW +: DW] = nq[n][0][15:0];
      end else begin
        req_type[n*2 +: 2]   = 2'd0;
        req_addr[n*AW +: AW] = '0;
        req_data[n*DW +: DW] = '0;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<50000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    req_valid = '0; req_type = '0; req_addr = '0; req_data = '0;
    done_count = 3'd0;
    nq[0].push_back(pk(2, 3, 'h1234)); nq[0].push_back(pk(1, 3, 0));
    nq[1].push_back(pk(1, 3, 0));      nq[1].push_back(pk(2, 5, 'hBEEF));
    nq[2].push_back(pk(1, 5, 0));      nq[2].push_back(pk(1, 9, 0));
    nq[3].push_back(pk(2, 9, 'h0042)); nq[3].push_back(pk(1, 3, 0));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 grant in reset", int'(grant), 0);
    chk("R1 bus_valid in reset", int'(bus_valid), 0);
    chk("R1 run_stop in reset", int'(run_stop), 0);
    rst_n = 1'b1;
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk);
      if (nq[0].size() + nq[1].size() + nq[2].size() + nq[3].size() == 0 && grant == '0) break;
    end
    // R3 rotation from node 0 under full contention
    chk("R3 order size", order.size(), 8);
    for (int i = 0; i < 8 && i < order.size(); i++) chk("R3 winner order", order[i], i % N);
    // R9: count below total keeps running, then reaching it stops new grants
    done_count = 3'd3;
    nq[1].push_back(pk(1, 5, 0)); nq[1].push_back(pk(1, 9, 0)); nq[1].push_back(pk(1, 3, 0));
    repeat (3) @(negedge clk);
    chk("R9 no stop below total", int'(run_stop), 0);
    done_count = 3'd4;
    repeat (40) @(negedge clk);
    chk("R9 stop raised", int'(run_stop), 1);
    chk("R9 grant idle after stop", int'(grant), 0);
    chk("R9 queued requests never granted", int'(nq[1].size() > 0), 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule